// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave (4 Kbit)

This block is a 512-byte serial EEPROM that answers as a slave on a two-wire I2C bus. It does not sample the raw bus lines. A line conditioner in front of it supplies single-cycle strobes for the start condition, the stop condition and each SCL edge, together with the filtered SDA level. The block drives SDA only through an open-drain pull enable.

A master selects one of up to four such devices by the two strap inputs. It writes one byte or a page of up to sixteen bytes. It reads at a random address, at the current address, or as a sequential stream. A write-protect input stops every write to the array. Each committed write keeps the device busy for a programmable number of system clocks. During that time the device does not acknowledge its address, so the master can poll until the write is complete.

Writes are collected in a page buffer. They reach the array only when a stop condition follows. The copy into the array runs during the busy window, while the device is closed to the bus.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset the SDA pull enable is released, the device is not busy, and its first matching address byte is acknowledged.
- R2: The address byte is sent MSB first and has the form prefix[7:4], strap[3:2], word-address bit 8 [1], direction [0] (1 = read). The device acknowledges only when the prefix is 4'b1010 and strap equals `addr_sel`. Any other byte gets no acknowledge.
- R3: SDA is sampled on the rising-edge strobe. The pull enable changes only in the cycle after a falling-edge, start or stop strobe, so it stays steady while SCL is high. A read bit is shown as pull = NOT bit.
- R4: A write sends the address byte (direction 0), then word address bits [7:0], then data bytes. Address bits [3:0] step after each data byte and wrap inside the 16-byte page, so later bytes overwrite earlier ones. Data is committed only when a stop follows, and the current address is then the last written slot plus one, inside the page.
- R5: With `write_lock` high at the stop, data bytes are still acknowledged, but no write cycle starts and the array keeps its contents.
- R6: After a committed write the device gives no acknowledge to its address for `WR_CYCLES` clocks, then acknowledges again.
- R7: A random read is a dummy write of the word address, a repeated start, and an address byte with direction 1. It returns the byte at that address.
- R8: A read that starts without a new word address returns the byte at the current address. Bit 1 of that address byte has no effect.
- R9: During a sequential read the address advances after every byte and wraps from 511 to 0. After a master NACK the device releases SDA until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | Start or repeated-start strobe from the line conditioner |
| bus_stop | input | 1 | Stop strobe from the line conditioner |
| scl_rise | input | 1 | SCL rising-edge strobe |
| scl_fall | input | 1 | SCL falling-edge strobe |
| sda_in | input | 1 | Filtered SDA level |
| addr_sel | input | 2 | Strap value that the address byte must match |
| write_lock | input | 1 | High blocks all writes to the array |
| sda_pull | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
Two functions meet within one transaction. The first is the end of a write at the stop, where the write-protect level decides whether a write cycle starts. The second is the address decode of the very next transaction, which must follow the busy state that the stop produced. The bench provokes this by probing the address right after a stop, once after a real commit and once with protection on, and it judges the result by the acknowledge bit and by reading the array back. A second overlap is the page wrap. There the buffered slots are overwritten before the commit, and the bench compares the whole page against a model that applies the same wrap arithmetic.

// File: rtl/serial_eeprom_pkg.sv
`timescale 1ns/1ps
package serial_eeprom_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADDR,
    ST_WADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } eep_state_t;

  localparam logic [3:0] DEV_TYPE_CODE = 4'b1010;
endpackage

// File: rtl/serial_eeprom_array.sv
`timescale 1ns/1ps
// Simple dual-port byte array, one write and one registered read port.
module serial_eeprom_array #(
  parameter int DEPTH = 512,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/serial_eeprom_pagebuf.sv
`timescale 1ns/1ps
// Page staging buffer with a valid flag for each slot.
module serial_eeprom_pagebuf #(
  parameter int SLOTS = 16,
  parameter int DW    = 8,
  localparam int IW   = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ridx,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  logic [DW-1:0]    slot_q [SLOTS];
  logic [SLOTS-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      vld_q <= '0;
    end else if (we) begin
      vld_q[widx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (we) slot_q[widx] <= wdata;
  end

  assign rdata  = slot_q[ridx];
  assign rvalid = vld_q[ridx];
endmodule

// File: rtl/serial_eeprom_wrtimer.sv
`timescale 1ns/1ps
// Write-cycle timer. The first SLOTS cycles of the busy window index the commit.
module serial_eeprom_wrtimer #(
  parameter int WR_CYCLES = 625000,
  parameter int SLOTS     = 16,
  localparam int IW       = $clog2(SLOTS),
  localparam int CW       = $clog2(WR_CYCLES + SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  output logic          busy,
  output logic          commit_en,
  output logic [IW-1:0] commit_idx
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (go) begin
      busy  <= 1'b1;
      cnt_q <= '0;
    end else if (busy) begin
      if (cnt_q == CW'(WR_CYCLES - 1)) busy <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign commit_en  = busy && (cnt_q < CW'(SLOTS));
  assign commit_idx = cnt_q[IW-1:0];
endmodule

// File: rtl/serial_eeprom_slave.sv
`timescale 1ns/1ps
module serial_eeprom_slave
  import serial_eeprom_pkg::*;
#(
  parameter int MEM_BYTES  = 512,
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 625000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_start,
  input  logic       bus_stop,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_in,
  input  logic [1:0] addr_sel,
  input  logic       write_lock,
  output logic       sda_pull
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int HW = AW - PW;

  eep_state_t    state;
  logic [3:0]    bit_cnt;
  logic [7:0]    shreg, tx;
  logic          rw_q, a8_q, mack_q, have_data;
  logic [AW-1:0] ptr;
  logic [HW-1:0] page_hi;

  logic [7:0]    rd_byte, buf_rdata;
  logic          buf_rvalid, busy, commit_en, mem_we;
  logic [PW-1:0] commit_idx;

  logic byte_done, ctrl_evt, dev_match, rx_state, buf_we, buf_clr, commit_go;

  assign ctrl_evt  = bus_start || bus_stop;
  assign byte_done = scl_fall && (bit_cnt == 4'd8);
  assign dev_match = (shreg[7:4] == DEV_TYPE_CODE) && (shreg[3:2] == addr_sel);
  assign rx_state  = (state == ST_DEV) || (state == ST_WADDR) || (state == ST_WDATA);
  assign buf_we    = !ctrl_evt && (state == ST_WDATA) && byte_done;
  assign buf_clr   = !ctrl_evt && (state == ST_WADDR) && byte_done;
  assign commit_go = bus_stop && have_data && !write_lock;
  assign mem_we    = commit_en && buf_rvalid;

  serial_eeprom_array #(.DEPTH(MEM_BYTES), .DW(8)) u_array (
    .clk   (clk),
    .we    (mem_we),
    .waddr ({page_hi, commit_idx}),
    .wdata (buf_rdata),
    .raddr (ptr),
    .rdata (rd_byte)
  );

  serial_eeprom_pagebuf #(.SLOTS(PAGE_BYTES), .DW(8)) u_pagebuf (
    .clk    (clk),
    .rst    (rst),
    .clr    (buf_clr),
    .we     (buf_we),
    .widx   (ptr[PW-1:0]),
    .wdata  (shreg),
    .ridx   (commit_idx),
    .rdata  (buf_rdata),
    .rvalid (buf_rvalid)
  );

  serial_eeprom_wrtimer #(.WR_CYCLES(WR_CYCLES), .SLOTS(PAGE_BYTES)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .go         (commit_go),
    .busy       (busy),
    .commit_en  (commit_en),
    .commit_idx (commit_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      tx        <= '0;
      rw_q      <= 1'b0;
      a8_q      <= 1'b0;
      mack_q    <= 1'b0;
      have_data <= 1'b0;
      ptr       <= '0;
      page_hi   <= '0;
      sda_pull  <= 1'b0;
    end else if (bus_stop) begin
      state     <= ST_IDLE;
      sda_pull  <= 1'b0;
      have_data <= 1'b0;
      bit_cnt   <= '0;
    end else if (bus_start) begin
      state     <= ST_DEV;
      sda_pull  <= 1'b0;
      have_data <= 1'b0;
      bit_cnt   <= '0;
    end else begin
      // receive shifter, sampled on the rising edge
      if (rx_state && scl_rise && bit_cnt != 4'd8) begin
        shreg   <= {shreg[6:0], sda_in};
        bit_cnt <= bit_cnt + 4'd1;
      end
      unique case (state)
        ST_IDLE: ;
        ST_DEV: begin
          if (byte_done) begin
            bit_cnt <= '0;
            if (dev_match && !busy) begin
              sda_pull <= 1'b1;
              rw_q     <= shreg[0];
              a8_q     <= shreg[1];
              state    <= ST_DEV_ACK;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_WADDR: begin
          if (byte_done) begin
            bit_cnt  <= '0;
            ptr      <= {a8_q, shreg[AW-2:0]};
            page_hi  <= {a8_q, shreg[AW-2:PW]};
            sda_pull <= 1'b1;
            state    <= ST_WADDR_ACK;
          end
        end
        ST_WDATA: begin
          if (byte_done) begin
            bit_cnt        <= '0;
            ptr[PW-1:0]    <= ptr[PW-1:0] + 1'b1;
            have_data      <= 1'b1;
            sda_pull       <= 1'b1;
            state          <= ST_WDATA_ACK;
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (rw_q) begin
              state    <= ST_RDATA;
              sda_pull <= ~rd_byte[7];
              tx       <= {rd_byte[6:0], 1'b0};
            end else begin
              state    <= ST_WADDR;
              sda_pull <= 1'b0;
            end
          end
        end
        ST_WADDR_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            sda_pull <= 1'b0;
            bit_cnt  <= '0;
            state    <= ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_rise) bit_cnt <= bit_cnt + 4'd1;
          if (scl_fall) begin
            if (bit_cnt == 4'd8) begin
              sda_pull <= 1'b0;
              ptr      <= ptr + 1'b1;
              state    <= ST_RACK;
            end else begin
              sda_pull <= ~tx[7];
              tx       <= {tx[6:0], 1'b0};
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) mack_q <= ~sda_in;
          if (scl_fall) begin
            bit_cnt <= '0;
            if (mack_q) begin
              state    <= ST_RDATA;
              sda_pull <= ~rd_byte[7];
              tx       <= {rd_byte[6:0], 1'b0};
            end else begin
              state    <= ST_IDLE;
              sda_pull <= 1'b0;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_eeprom_chk.sv
`timescale 1ns/1ps
module serial_eeprom_chk
  import serial_eeprom_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       bus_start,
  input logic       bus_stop,
  input logic       scl_fall,
  input logic       write_lock,
  input logic       sda_pull,
  input logic       busy,
  input logic       mem_we,
  input eep_state_t state
);
  // R3
  sda_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (sda_pull != $past(sda_pull)) |-> $past(scl_fall || bus_start || bus_stop));

  // R4
  commit_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  // R5
  lock_no_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(bus_stop && !write_lock));

  // R6
  busy_nack_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(sda_pull) && $past(state) == ST_DEV) |-> !$past(busy));

  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    $past(bus_stop) |-> (state == ST_IDLE && !sda_pull));
endmodule

bind serial_eeprom_slave serial_eeprom_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_start  (bus_start),
  .bus_stop   (bus_stop),
  .scl_fall   (scl_fall),
  .write_lock (write_lock),
  .sda_pull   (sda_pull),
  .busy       (busy),
  .mem_we     (mem_we),
  .state      (state)
);

// File: tb/serial_eeprom_slave_tb.sv
`timescale 1ns/1ps
module serial_eeprom_slave_tb;
  localparam int WRC = 300;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_start = 1'b0, bus_stop = 1'b0, scl_rise = 1'b0, scl_fall = 1'b0;
  logic sda_m = 1'b1, wlock = 1'b0;
  logic [1:0] sel = 2'b10;
  logic sda_pull, sda_bus;

  assign sda_bus = sda_m & ~sda_pull;
  always #4 clk = ~clk;

  serial_eeprom_slave #(.MEM_BYTES(512), .PAGE_BYTES(16), .WR_CYCLES(WRC)) u_dut (
    .clk(clk), .rst(rst), .bus_start(bus_start), .bus_stop(bus_stop),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_bus),
    .addr_sel(sel), .write_lock(wlock), .sda_pull(sda_pull)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] model [512];
  int ptr_m = 0;

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic p_rise(); scl_rise = 1'b1; tick(1); scl_rise = 1'b0; endtask
  task automatic p_fall(); scl_fall = 1'b1; tick(1); scl_fall = 1'b0; endtask
  task automatic b_start(); bus_start = 1'b1; tick(1); bus_start = 1'b0; tick(2); endtask
  task automatic b_stop(); bus_stop = 1'b1; tick(1); bus_stop = 1'b0; tick(2); endtask

  task automatic bit_tx(logic b);
    sda_m = b; tick(2); p_rise(); tick(2); p_fall(); tick(2);
  endtask

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37) + ((a >> 8) * 11) + 5);
  endfunction

  function automatic logic [7:0] dev(logic [3:0] p, logic [1:0] s, logic a8, logic rw);
    return {p, s, a8, rw};
  endfunction

  task automatic send_byte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) bit_tx(b[i]);
    sda_m = 1'b1;
    ack = sda_pull;
    p_rise(); tick(2); p_fall(); tick(2);
  endtask

  task automatic recv_byte(logic mack, output logic [7:0] b);
    logic v1, v2;
    for (int i = 7; i >= 0; i--) begin
      v1 = sda_bus;
      p_rise(); v2 = sda_bus;
      check("R3 bit steady while SCL high", v2, v1);
      b[i] = v1;
      tick(1); p_fall(); tick(2);
    end
    sda_m = !mack; tick(1); p_rise(); tick(2); p_fall();
    sda_m = 1'b1; tick(2);
  endtask

  task automatic probe(output logic ack);
    b_start(); send_byte(dev(4'b1010, sel, 1'b0, 1'b0), ack); b_stop();
  endtask

  task automatic write_run(logic [8:0] addr, int n, bit use_pat, string tag);
    logic ack;
    int a;
    logic [7:0] v;
    b_start();
    send_byte(dev(4'b1010, sel, addr[8], 1'b0), ack); check(tag, ack, 1);
    send_byte(addr[7:0], ack); check(tag, ack, 1);
    for (int i = 0; i < n; i++) begin
      a = (int'(addr) & ~15) | ((int'(addr) + i) & 15);
      v = use_pat ? pat(a) : 8'(8'hC0 + i);
      send_byte(v, ack); check(tag, ack, 1);
      if (!wlock) model[a] = v;
    end
    b_stop();
    ptr_m = (int'(addr) & ~15) | ((int'(addr) + n) & 15);
  endtask

  task automatic read_run(logic [8:0] addr, int n, bit rnd, logic a8f, string tag);
    logic ack;
    logic [7:0] b;
    if (rnd) begin
      b_start();
      send_byte(dev(4'b1010, sel, addr[8], 1'b0), ack); check(tag, ack, 1);
      send_byte(addr[7:0], ack); check(tag, ack, 1);
      ptr_m = int'(addr);
    end
    b_start();
    send_byte(dev(4'b1010, sel, a8f, 1'b1), ack); check(tag, ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      check(tag, b, model[ptr_m]);
      ptr_m = (ptr_m + 1) % 512;
    end
    // R9: released after the master NACK
    bit_tx(1'b1);
    check("R9 released after NACK", sda_pull, 0);
    b_stop();
  endtask

  initial begin
    logic ack;
    tick(5); rst = 1'b0; tick(2);
    check("R1 pull released at reset", sda_pull, 0);
    probe(ack);
    check("R1 not busy after reset", ack, 1);

    // R2: sweep every prefix and strap value
    for (int p = 0; p < 16; p++)
      for (int s = 0; s < 4; s++) begin
        b_start();
        send_byte(dev(4'(p), 2'(s), 1'b0, 1'b0), ack);
        b_stop();
        check("R2 address match", ack, (p == 10 && s == 2) ? 1 : 0);
      end

    // R4 fill the array page by page; R6 busy window on the first page
    for (int pg = 0; pg < 32; pg++) begin
      write_run(9'(pg * 16), 16, 1'b1, "R4 page write ack");
      if (pg == 0) begin
        probe(ack); check("R6 nack while busy", ack, 0);
        tick(WRC + 20);
        probe(ack); check("R6 ack after write cycle", ack, 1);
      end else begin
        tick(WRC + 20);
      end
    end

    // R9 sequential read over the whole array, wrapping to 0
    read_run(9'd0, 514, 1'b1, 1'b0, "R9 sequential read");
    // R8 current address (ptr 2), with address bit 1 set
    read_run(9'd0, 1, 1'b0, 1'b1, "R8 current address read");

    // R4 page wrap: 20 bytes from 0x1F5
    write_run(9'h1F5, 20, 1'b0, "R4 wrap write ack");
    tick(WRC + 20);
    read_run(9'd0, 1, 1'b0, 1'b0, "R4 pointer after page write");
    read_run(9'h1F0, 16, 1'b1, 1'b0, "R4 page wrap contents");

    // R5 write lock
    wlock = 1'b1;
    write_run(9'h010, 3, 1'b0, "R5 locked data ack");
    probe(ack); check("R5 no write cycle when locked", ack, 1);
    wlock = 1'b0;
    read_run(9'h010, 3, 1'b1, 1'b0, "R5 array unchanged");

    // R7 byte write then random reads
    write_run(9'h0AB, 1, 1'b0, "R7 byte write ack");
    tick(WRC + 20);
    read_run(9'h0AB, 1, 1'b1, 1'b0, "R7 random read");
    read_run(9'h1FF, 2, 1'b1, 1'b0, "R7 random read top");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule